// File: doc/BRIEF.md
# Half-Chip Code Phase Tracker with Strobe Capture

This block follows the spreading-code position of one correlator channel. An 11-bit up-counter measures position in half-chip units. It moves forward one step on each half-chip enable, and the end-of-code epoch pulse returns it to zero. The same epoch pulse advances an 8-bit epoch counter. A count of 2046 seen with the old epoch means the same thing as a count of 0 seen with the new epoch.

A measurement strobe freezes the current phase and epoch into read registers, so software can collect a consistent pair at its leisure. If the strobe arrives while the code generator is slewing, the captured phase is forced to zero. While slewing, the counter itself stands still. For test purposes only, a write strobe can load the counter directly, and only when the test-mode enable is high.

Top module: `code_phase_tracker`

## Requirements
- R1: When hc_step is 1, slew_busy is 0, epoch_end is 0, no test load happens and live_phase is below 2046, live_phase increases by exactly one on the next clock.
- R2: When epoch_end is 1 and no test load happens in the same cycle, live_phase is 0 on the next clock.
- R3: Each cycle with epoch_end at 1 increases the epoch count by one, modulo 256. The epoch count is otherwise unchanged.
- R4: A cycle with meas_strobe at 1 and slew_busy at 0 loads phase_rd[10:0] with live_phase and held_epoch with the epoch count, both as they stood before that clock edge, even when hc_step or epoch_end is also high in that cycle. Without meas_strobe, both read values hold.
- R5: A cycle with meas_strobe at 1 and slew_busy at 1 loads phase_rd with 0, while held_epoch still takes the epoch count.
- R6: A cycle with tst_wr and tst_mode both at 1 loads live_phase with tst_data on the next clock. This load takes priority over epoch_end in the same cycle.
- R7: When tst_mode is 0, tst_wr has no effect on live_phase.
- R8: After a synchronous reset, phase_rd, held_epoch and live_phase are all 0. Bits 15:11 of phase_rd always read 0.
- R9: While slew_busy is 1, and neither epoch_end nor a test load happens, live_phase holds its value.
- R10: Once live_phase has reached 2046 or more, hc_step does not move it again. It waits for epoch_end or a test load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hc_step | input | 1 | Half-chip advance enable |
| epoch_end | input | 1 | End-of-code-epoch pulse |
| meas_strobe | input | 1 | Measurement capture strobe |
| slew_busy | input | 1 | Code slew in progress |
| tst_mode | input | 1 | Test-mode enable for direct loads |
| tst_wr | input | 1 | Direct-load write strobe |
| tst_data | input | 11 | Value for the direct load |
| phase_rd | output | 16 | Captured phase, upper bits zero |
| held_epoch | output | 8 | Epoch count captured with the phase |
| live_phase | output | 11 | Running counter value |

## Verification
The assertions assume that every control input is a known 0 or 1 on every clock edge after reset. They also assume that reset is held for at least one edge before any check starts. The bench drives all inputs only on falling edges and never leaves them undriven. Random stimulus covers every mix of the control pulses, including several pulses in the same cycle. Directed stretches add long runs without an epoch pulse to reach the 2046 ceiling, write attempts with test mode off, and enough epoch pulses to wrap the epoch count.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    localparam int PHASE_W_DEF = 11;
    localparam int EPOCH_W_DEF = 8;
    localparam int REG_W_DEF   = 16;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_CLEAR = 2'd2,
        ACT_LOAD  = 2'd3
    } cnt_act_e;

    // Priority: test load, then epoch clear, then slew hold, then step.
    function automatic cnt_act_e pick_action(
        input logic load,
        input logic clear,
        input logic freeze,
        input logic step,
        input logic below_top
    );
        if (load)
            return ACT_LOAD;
        else if (clear)
            return ACT_CLEAR;
        else if (freeze)
            return ACT_HOLD;
        else if (step && below_top)
            return ACT_STEP;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/cpc_phase_counter.sv
module cpc_phase_counter
    import cpc_pkg::*;
#(
    parameter int PHASE_W    = PHASE_W_DEF,
    parameter int PHASE_LAST = (1 << PHASE_W_DEF) - 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               clear,
    input  logic               freeze,
    input  logic               load,
    input  logic [PHASE_W-1:0] load_val,
    output logic [PHASE_W-1:0] count
);

    localparam logic [PHASE_W-1:0] TOP = PHASE_W'(PHASE_LAST);

    cnt_act_e act;

    always_comb begin
        act = pick_action(load, clear, freeze, step, count < TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (act)
                ACT_LOAD:  count <= load_val;
                ACT_CLEAR: count <= '0;
                ACT_STEP:  count <= count + 1'b1;
                default:   count <= count;
            endcase
        end
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (step && !freeze && !clear && !load && count < TOP)
        |=> count == PHASE_W'($past(count) + 1'b1)); // R1

    AST_EPOCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clear && !load) |=> count == '0); // R2

    AST_TEST_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val)); // R6

    AST_SLEW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clear && !load) |=> $stable(count)); // R9

    AST_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (count >= TOP && !clear && !load) |=> $stable(count)); // R10

endmodule

// File: rtl/cpc_epoch_counter.sv
module cpc_epoch_counter #(
    parameter int EPOCH_W = cpc_pkg::EPOCH_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bump,
    output logic [EPOCH_W-1:0] epoch
);

    always_ff @(posedge clk) begin
        if (rst)
            epoch <= '0;
        else if (bump)
            epoch <= epoch + 1'b1;
    end

    AST_EPOCH_BUMP: assert property (@(posedge clk) disable iff (rst)
        bump |=> epoch == EPOCH_W'($past(epoch) + 1'b1)); // R3

    AST_EPOCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bump |=> $stable(epoch)); // R3

endmodule

// File: rtl/cpc_capture.sv
module cpc_capture #(
    parameter int PHASE_W = cpc_pkg::PHASE_W_DEF,
    parameter int EPOCH_W = cpc_pkg::EPOCH_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               snap,
    input  logic               slewing,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic [EPOCH_W-1:0] epoch_in,
    output logic [PHASE_W-1:0] phase_q,
    output logic [EPOCH_W-1:0] epoch_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            epoch_q <= '0;
        end else if (snap) begin
            phase_q <= slewing ? '0 : phase_in;
            epoch_q <= epoch_in;
        end
    end

    AST_SNAP_PHASE: assert property (@(posedge clk) disable iff (rst)
        (snap && !slewing) |=> phase_q == $past(phase_in)); // R4

    AST_SNAP_EPOCH: assert property (@(posedge clk) disable iff (rst)
        snap |=> epoch_q == $past(epoch_in)); // R4

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !snap |=> ($stable(phase_q) && $stable(epoch_q))); // R4

    AST_SLEW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (snap && slewing) |=> phase_q == '0); // R5

endmodule

// File: rtl/code_phase_tracker.sv
module code_phase_tracker
    import cpc_pkg::*;
#(
    parameter int PHASE_W = PHASE_W_DEF,
    parameter int EPOCH_W = EPOCH_W_DEF,
    parameter int REG_W   = REG_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hc_step,
    input  logic               epoch_end,
    input  logic               meas_strobe,
    input  logic               slew_busy,
    input  logic               tst_mode,
    input  logic               tst_wr,
    input  logic [PHASE_W-1:0] tst_data,
    output logic [REG_W-1:0]   phase_rd,
    output logic [EPOCH_W-1:0] held_epoch,
    output logic [PHASE_W-1:0] live_phase
);

    localparam int PHASE_LAST = (1 << PHASE_W) - 2;
    localparam int PAD_W      = REG_W - PHASE_W;

    logic               do_load;
    logic [EPOCH_W-1:0] epoch_now;
    logic [PHASE_W-1:0] cap_phase;

    assign do_load = tst_wr & tst_mode;

    cpc_phase_counter #(
        .PHASE_W    (PHASE_W),
        .PHASE_LAST (PHASE_LAST)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .step     (hc_step),
        .clear    (epoch_end),
        .freeze   (slew_busy),
        .load     (do_load),
        .load_val (tst_data),
        .count    (live_phase)
    );

    cpc_epoch_counter #(
        .EPOCH_W (EPOCH_W)
    ) u_epoch (
        .clk   (clk),
        .rst   (rst),
        .bump  (epoch_end),
        .epoch (epoch_now)
    );

    cpc_capture #(
        .PHASE_W (PHASE_W),
        .EPOCH_W (EPOCH_W)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .snap     (meas_strobe),
        .slewing  (slew_busy),
        .phase_in (live_phase),
        .epoch_in (epoch_now),
        .phase_q  (cap_phase),
        .epoch_q  (held_epoch)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign phase_rd = {{PAD_W{1'b0}}, cap_phase};
        end else begin : g_nopad
            assign phase_rd = cap_phase[REG_W-1:0];
        end
    endgenerate

    AST_NO_TEST_WRITE: assert property (@(posedge clk) disable iff (rst)
        (tst_wr && !tst_mode && !epoch_end && slew_busy) |=> $stable(live_phase)); // R7

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (phase_rd == '0 && held_epoch == '0 && live_phase == '0)); // R8

endmodule

// File: tb/sim_code_phase_tracker.sv
module sim_code_phase_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hc_step = 0, epoch_end = 0, meas_strobe = 0, slew_busy = 0;
    logic        tst_mode = 0, tst_wr = 0;
    logic [10:0] tst_data = '0;
    logic [15:0] phase_rd;
    logic [7:0]  held_epoch;
    logic [10:0] live_phase;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int m_cnt = 0, m_ep = 0, m_cap = 0, m_cep = 0;
    string cnt_tag = "R8";
    string cap_tag = "R8";

    always #4 clk = ~clk;

    code_phase_tracker u0 (
        .clk(clk), .rst(rst), .hc_step(hc_step), .epoch_end(epoch_end),
        .meas_strobe(meas_strobe), .slew_busy(slew_busy), .tst_mode(tst_mode),
        .tst_wr(tst_wr), .tst_data(tst_data), .phase_rd(phase_rd),
        .held_epoch(held_epoch), .live_phase(live_phase)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(cnt_tag, int'(live_phase), m_cnt);
        chk("R3 epoch", int'(held_epoch) , m_cep);
        chk(cap_tag, int'(phase_rd[10:0]), m_cap);
        chk("R8 upper", int'(phase_rd[15:11]), 0);
    endtask

    task automatic model_step();
        bit ld;
        ld = tst_wr && tst_mode;
        if (rst) begin
            m_cnt = 0; m_ep = 0; m_cap = 0; m_cep = 0;
            cnt_tag = "R8"; cap_tag = "R8";
            return;
        end
        if (meas_strobe) begin
            m_cap = slew_busy ? 0 : m_cnt;
            m_cep = m_ep;
            cap_tag = slew_busy ? "R5 slew capture" : "R4 capture";
        end else begin
            cap_tag = "R4 hold";
        end
        if (epoch_end) m_ep = (m_ep + 1) % 256;
        if (ld) begin
            m_cnt = int'(tst_data); cnt_tag = "R6 load";
        end else if (epoch_end) begin
            m_cnt = 0; cnt_tag = "R2 clear";
        end else if (slew_busy) begin
            cnt_tag = tst_wr ? "R7 R9 hold" : "R9 hold";
        end else if (hc_step && m_cnt < 2046) begin
            m_cnt++; cnt_tag = "R1 step";
        end else begin
            cnt_tag = (m_cnt >= 2046) ? "R10 top" : (tst_wr ? "R7 ignored" : "R1 idle");
        end
    endtask

    // One cycle: check the previous edge's result, apply inputs, advance model.
    task automatic cyc(bit h, bit d, bit t, bit s, bit tm, bit w, int wd);
        compare_all();
        hc_step = h; epoch_end = d; meas_strobe = t; slew_busy = s;
        tst_mode = tm; tst_wr = w; tst_data = 11'(wd);
        model_step();
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        model_step();
        @(negedge clk);
        compare_all();                        // R8 reset state
        rst = 1'b0;
        model_step();
        @(negedge clk);
        // R1, R10: long run without epoch pulse reaches and holds at 2046
        for (int i = 0; i < 2060; i++) cyc(1, 0, (i % 97) == 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);             // R4 capture at 2046
        cyc(1, 1, 1, 0, 0, 0, 0);             // R4/R2: capture pre-clear, epoch old
        cyc(1, 0, 1, 0, 0, 0, 0);             // R4: capture of 0 with new epoch
        // R7: write without test mode
        cyc(0, 0, 0, 0, 0, 1, 1234);
        cyc(1, 0, 0, 0, 0, 1, 500);
        // R6: loads, including priority over epoch pulse
        cyc(0, 0, 0, 0, 1, 1, 2040);
        cyc(1, 1, 0, 0, 1, 1, 2045);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 1, 2047);          // R10 above top holds
        cyc(1, 0, 0, 0, 0, 0, 0);
        // R9, R5: slew hold and capture during slew
        cyc(1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(1, 0, i == 3, 1, 0, i == 4, 77);
        cyc(0, 0, 1, 0, 0, 0, 0);
        // R3: wrap the epoch count
        for (int i = 0; i < 300; i++) cyc(1, 1, (i % 50) == 0, 0, 0, 0, 0);
        // Mixed random traffic
        for (int i = 0; i < 6000; i++) begin
            cyc(($urandom % 4) != 0, ($urandom % 150) == 0, ($urandom % 9) == 0,
                ($urandom % 6) == 0, ($urandom % 2) == 0, ($urandom % 40) == 0,
                2030 + int'($urandom % 18));
        end
        // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 all covered above
        compare_all();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule